// File: doc/BRIEF.md
# Reentrant Lock Entry-Count Cache

This block speeds up the common case in which a thread takes an object lock it already holds, or gives back one of several nested holds. It keeps a small associative table. Each entry holds a lock object address, a valid flag and a nesting count. A count request carries an object address and is either an enter or an exit. It is compared with every valid entry at once. A hit adjusts the count in hardware. Every other case raises a trap with a cause code, so that software can handle it. These cases are a miss, a count that would overflow or underflow, contention and a waiting thread.

Software alone fills and evicts the table. It reads and writes every field of every entry through an indexed register port.

The same request port also runs the header check on an object's header word. Bit 0 of that word is the held flag and bit 1 is the waiter flag. A first enter tests and sets the held flag. A final exit clears it and reports a waiter. A plain header read returns the word with both flags hidden.

Every request returns one response, registered, in the cycle after it is accepted.

Top module: `lock_reentry_cache`

## Requirements
- R1: After reset every entry is invalid with address 0 and count 0, and rsp_valid is low.
- R2: The op field of req_op selects the operation: code 0 is enter, 1 is exit, 2 is header read, 3 is header lock and 4 is header unlock. An enter whose address matches a valid entry adds one to that entry's count. The bench sees a response one cycle later with rsp_trap low and rsp_idx set to that entry.
- R3: An exit that hits subtracts one from the count. rsp_release is high exactly when the new count is 0, and rsp_trap is low.
- R4: A count request whose address matches no valid entry gives rsp_trap high with cause 1 (miss). It leaves every entry unchanged.
- R5: An enter that hits an entry whose count is all ones gives cause 4 (count error). So does an exit that hits a count of 0. In both cases the count is unchanged.
- R6: A header read returns req_hdr with bits 1:0 forced to 0 and no trap. Op codes 5, 6 and 7 behave the same way.
- R7: A header lock with bit 0 clear returns the word with bit 0 set and no trap. With bit 0 already set, it returns the word unchanged, with rsp_trap high and cause 2 (contention).
- R8: A header unlock returns the word with bit 0 cleared. If bit 1 is set it also raises rsp_trap with cause 3 (waiter present). Otherwise there is no trap.
- R9: The software port selects entry sw_idx and a field with sw_field: 0 is the address, 1 is the count in the low bits and 2 is the valid flag in bit 0. sw_rdata shows that field in the same cycle. A write with sw_we takes effect at the next clock edge.
- R10: A software write in a cycle where req_valid is high is dropped.
- R11: If several valid entries match, the lowest-numbered entry is used.
- R12: For enter and exit responses, rsp_hdr is 0. A miss reports rsp_idx 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Lock object address for count requests |
| req_hdr | input | HW | Object header word for header requests |
| sw_we | input | 1 | Software write strobe |
| sw_idx | input | IW | Entry index for software access |
| sw_field | input | 2 | Field select for software access |
| sw_wdata | input | AW | Software write data |
| sw_rdata | output | AW | Selected field, combinational |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_trap | output | 1 | Trap request |
| rsp_cause | output | 3 | Trap cause code |
| rsp_release | output | 1 | Exit brought the count to zero |
| rsp_idx | output | IW | Entry that hit |
| rsp_hdr | output | HW | Header word result |

## Verification
The assertions check these rules on every cycle:
- no count ever steps past its limit in either direction, and a hit moves its count by exactly one;
- a miss and a dropped software write leave the table untouched;
- a release never comes with a trap;
- the header results keep the flag rules: reads hide both flags, a granted lock shows the held flag, and an unlock clears it.

The bench scenarios are needed for the rest:
- the exact cause code in each trap case;
- the point at which the count reaches its limit;
- the lowest-index choice when entries are duplicated;
- the same-cycle readback of the software port.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [2:0] {
    OP_ENTER   = 3'd0,
    OP_EXIT    = 3'd1,
    OP_HREAD   = 3'd2,
    OP_HLOCK   = 3'd3,
    OP_HUNLOCK = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    TC_NONE    = 3'd0,
    TC_MISS    = 3'd1,
    TC_CONTEND = 3'd2,
    TC_WAITER  = 3'd3,
    TC_COUNT   = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    FLD_ADDR  = 2'd0,
    FLD_CNT   = 2'd1,
    FLD_VALID = 2'd2
  } fld_e;

  localparam int HELD_BIT = 0;
  localparam int WAIT_BIT = 1;
endpackage

// File: rtl/lrc_entry.sv
module lrc_entry #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          wr_addr_i,
  input  logic          wr_cnt_i,
  input  logic          wr_vld_i,
  input  logic [AW-1:0] wdata_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          vld_q, vld_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  // next-state
  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (wr_vld_i)  vld_d  = wdata_i[0];
    if (wr_addr_i) addr_d = wdata_i;
    if (wr_cnt_i)       cnt_d = wdata_i[CW-1:0];
    else if (inc_i)     cnt_d = cnt_q + 1'b1;
    else if (dec_i)     cnt_d = cnt_q - 1'b1;
  end

  assign en = inc_i | dec_i | wr_addr_i | wr_cnt_i | wr_vld_i;

  // state register with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  p_no_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> (cnt_q != CMAX));
  p_no_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q != '0));
  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_i, dec_i}));
endmodule

// File: rtl/lrc_match.sv
module lrc_match #(
  parameter int AW   = 32,
  parameter int NENT = 2,
  parameter int IW   = 1
) (
  input  logic [NENT-1:0]         vld_i,
  input  logic [NENT-1:0][AW-1:0] addr_i,
  input  logic [AW-1:0]           key_i,
  output logic                    hit_o,
  output logic [IW-1:0]           idx_o
);
  logic [NENT-1:0] eq;

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign eq[g] = vld_i[g] && (addr_i[g] == key_i);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lrc_hdr.sv
module lrc_hdr
  import lrc_pkg::*;
#(
  parameter int HW = 32
) (
  input  op_e           op_i,
  input  logic [HW-1:0] word_i,
  output logic [HW-1:0] word_o,
  output logic          trap_o,
  output cause_e        cause_o
);
  always_comb begin
    word_o  = word_i;
    trap_o  = 1'b0;
    cause_o = TC_NONE;
    unique case (op_i)
      OP_HLOCK: begin
        if (word_i[HELD_BIT]) begin
          trap_o  = 1'b1;
          cause_o = TC_CONTEND;
        end else begin
          word_o[HELD_BIT] = 1'b1;
        end
      end
      OP_HUNLOCK: begin
        word_o[HELD_BIT] = 1'b0;
        if (word_i[WAIT_BIT]) begin
          trap_o  = 1'b1;
          cause_o = TC_WAITER;
        end
      end
      default: begin
        word_o[HELD_BIT] = 1'b0;
        word_o[WAIT_BIT] = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lock_reentry_cache.sv
module lock_reentry_cache
  import lrc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 4,
  parameter int NENT = 2,
  parameter int HW   = 32,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [HW-1:0] req_hdr,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [1:0]    sw_field,
  input  logic [AW-1:0] sw_wdata,
  output logic [AW-1:0] sw_rdata,
  output logic          rsp_valid,
  output logic          rsp_trap,
  output logic [2:0]    rsp_cause,
  output logic          rsp_release,
  output logic [IW-1:0] rsp_idx,
  output logic [HW-1:0] rsp_hdr
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  op_e  op;
  fld_e fld;
  logic is_enter, is_exit, is_cnt;

  assign op       = op_e'(req_op);
  assign fld      = fld_e'(sw_field);
  assign is_enter = req_valid && (op == OP_ENTER);
  assign is_exit  = req_valid && (op == OP_EXIT);
  assign is_cnt   = is_enter || is_exit;

  // entry table
  logic [NENT-1:0]         ent_vld;
  logic [NENT-1:0][AW-1:0] ent_addr;
  logic [NENT-1:0][CW-1:0] ent_cnt;
  logic [NENT-1:0]         inc_v, dec_v, wa_v, wc_v, wv_v;

  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [CW-1:0] cnt_sel;
  logic          at_max, at_zero, sw_ok;

  lrc_match #(.AW(AW), .NENT(NENT), .IW(IW)) u_match (
    .vld_i  (ent_vld),
    .addr_i (ent_addr),
    .key_i  (req_addr),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  assign cnt_sel = ent_cnt[hit_idx];
  assign at_max  = (cnt_sel == CMAX);
  assign at_zero = (cnt_sel == '0);
  assign sw_ok   = sw_we && !req_valid;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    assign inc_v[g] = is_enter && hit && (hit_idx == IW'(g)) && !at_max;
    assign dec_v[g] = is_exit  && hit && (hit_idx == IW'(g)) && !at_zero;
    assign wa_v[g]  = sw_ok && (sw_idx == IW'(g)) && (fld == FLD_ADDR);
    assign wc_v[g]  = sw_ok && (sw_idx == IW'(g)) && (fld == FLD_CNT);
    assign wv_v[g]  = sw_ok && (sw_idx == IW'(g)) && (fld == FLD_VALID);

    lrc_entry #(.AW(AW), .CW(CW)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (inc_v[g]),
      .dec_i     (dec_v[g]),
      .wr_addr_i (wa_v[g]),
      .wr_cnt_i  (wc_v[g]),
      .wr_vld_i  (wv_v[g]),
      .wdata_i   (sw_wdata),
      .vld_o     (ent_vld[g]),
      .addr_o    (ent_addr[g]),
      .cnt_o     (ent_cnt[g])
    );
  end

  // software readback
  always_comb begin
    sw_rdata = '0;
    unique case (fld)
      FLD_ADDR:  sw_rdata = ent_addr[sw_idx];
      FLD_CNT:   sw_rdata[CW-1:0] = ent_cnt[sw_idx];
      FLD_VALID: sw_rdata[0] = ent_vld[sw_idx];
      default:   sw_rdata = '0;
    endcase
  end

  // header check
  logic [HW-1:0] hdr_res;
  logic          hdr_trap;
  cause_e        hdr_cause;

  lrc_hdr #(.HW(HW)) u_hdr (
    .op_i    (op),
    .word_i  (req_hdr),
    .word_o  (hdr_res),
    .trap_o  (hdr_trap),
    .cause_o (hdr_cause)
  );

  // response next-state
  logic          trap_d, rel_d;
  cause_e        cause_d;
  logic [IW-1:0] idx_d;
  logic [HW-1:0] hdr_d;

  always_comb begin
    trap_d  = 1'b0;
    cause_d = TC_NONE;
    rel_d   = 1'b0;
    idx_d   = '0;
    hdr_d   = '0;
    if (is_cnt) begin
      if (!hit) begin
        trap_d  = 1'b1;
        cause_d = TC_MISS;
      end else begin
        idx_d = hit_idx;
        if ((is_enter && at_max) || (is_exit && at_zero)) begin
          trap_d  = 1'b1;
          cause_d = TC_COUNT;
        end else if (is_exit) begin
          rel_d = (cnt_sel == CW'(1));
        end
      end
    end else begin
      trap_d  = hdr_trap;
      cause_d = hdr_cause;
      hdr_d   = hdr_res;
    end
  end

  // response registers
  logic          vld_q, trap_q, rel_q;
  cause_e        cause_q;
  logic [IW-1:0] idx_q;
  logic [HW-1:0] hdr_q;
  op_e           op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      cause_q <= TC_NONE;
      rel_q   <= 1'b0;
      idx_q   <= '0;
      hdr_q   <= '0;
      op_q    <= OP_ENTER;
    end else if (req_valid) begin
      trap_q  <= trap_d;
      cause_q <= cause_d;
      rel_q   <= rel_d;
      idx_q   <= idx_d;
      hdr_q   <= hdr_d;
      op_q    <= op;
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_trap    = trap_q;
  assign rsp_cause   = cause_q;
  assign rsp_release = rel_q;
  assign rsp_idx     = idx_q;
  assign rsp_hdr     = hdr_q;

  p_release_no_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_release) |-> !rsp_trap);
  p_miss_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cnt && !hit) |=> ($stable(ent_cnt) && $stable(ent_vld) && $stable(ent_addr)));
  p_read_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_HREAD) |-> (rsp_hdr[WAIT_BIT:HELD_BIT] == 2'b00));
  p_lock_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_HLOCK && !rsp_trap) |-> rsp_hdr[HELD_BIT]);
  p_unlock_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_HUNLOCK) |-> !rsp_hdr[HELD_BIT]);
  p_sw_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sw_we) |=> ($stable(ent_addr) && $stable(ent_vld)));
endmodule

// File: tb/lock_reentry_cache_tb_top.sv
module lock_reentry_cache_tb_top;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int HW = 32;
  localparam int IW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [HW-1:0] req_hdr = '0;
  logic          sw_we = 1'b0;
  logic [IW-1:0] sw_idx = '0;
  logic [1:0]    sw_field = '0;
  logic [AW-1:0] sw_wdata = '0;
  logic [AW-1:0] sw_rdata;
  logic          rsp_valid, rsp_trap, rsp_release;
  logic [2:0]    rsp_cause;
  logic [IW-1:0] rsp_idx;
  logic [HW-1:0] rsp_hdr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic          trap;
    logic [2:0]    cause;
    logic          rel;
    logic [IW-1:0] idx;
    logic [HW-1:0] hdr;
    string         tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  lock_reentry_cache #(.AW(AW), .CW(CW), .NENT(2), .HW(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_hdr(req_hdr), .sw_we(sw_we), .sw_idx(sw_idx),
    .sw_field(sw_field), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
    .rsp_release(rsp_release), .rsp_idx(rsp_idx), .rsp_hdr(rsp_hdr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected response, actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " trap"},    64'(rsp_trap),    64'(e.trap));
        check({e.tag, " cause"},   64'(rsp_cause),   64'(e.cause));
        check({e.tag, " release"}, 64'(rsp_release), 64'(e.rel));
        check({e.tag, " idx"},     64'(rsp_idx),     64'(e.idx));
        check({e.tag, " hdr"},     64'(rsp_hdr),     64'(e.hdr));
      end
    end
  end

  task automatic do_req(input logic [2:0] op, input logic [AW-1:0] addr,
                        input logic [HW-1:0] hdr, input logic et,
                        input logic [2:0] ec, input logic er,
                        input logic [IW-1:0] ei, input logic [HW-1:0] eh,
                        input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_hdr = hdr;
    e.trap = et; e.cause = ec; e.rel = er; e.idx = ei; e.hdr = eh; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sw_write(input logic [IW-1:0] idx, input logic [1:0] f,
                          input logic [AW-1:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = idx; sw_field = f; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_check(input logic [IW-1:0] idx, input logic [1:0] f,
                          input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    sw_idx = idx; sw_field = f;
    #1;
    check(tag, 64'(sw_rdata), 64'(exp));
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1A00;
  localparam logic [AW-1:0] B = 32'h0000_2B00;
  localparam logic [AW-1:0] C = 32'h0000_3C00;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rsp_valid at reset", 64'(rsp_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    sw_check(0, 2, 0, "R1 e0 valid");
    sw_check(1, 2, 0, "R1 e1 valid");
    sw_check(0, 1, 0, "R1 e0 count");
    sw_check(1, 0, 0, "R1 e1 addr");

    do_req(3'd0, A, 0, 1, 3'd1, 0, 0, 0, "R4 miss on empty");

    sw_write(0, 0, A); sw_write(0, 1, 1); sw_write(0, 2, 1);
    sw_write(1, 0, B); sw_write(1, 2, 1);
    sw_check(0, 0, A, "R9 e0 addr");
    sw_check(0, 1, 1, "R9 e0 count");
    sw_check(1, 2, 1, "R9 e1 valid");

    do_req(3'd0, A, 0, 0, 3'd0, 0, 0, 0, "R2 enter hit");
    sw_check(0, 1, 2, "R2 count 2");
    do_req(3'd1, A, 0, 0, 3'd0, 0, 0, 0, "R3 exit no release");
    do_req(3'd1, A, 0, 0, 3'd0, 1, 0, 0, "R3 exit release");
    sw_check(0, 1, 0, "R3 count 0");
    do_req(3'd1, A, 0, 1, 3'd4, 0, 0, 0, "R5 exit at zero");
    sw_check(0, 1, 0, "R5 zero kept");

    for (int k = 0; k < 15; k++)
      do_req(3'd0, B, 0, 0, 3'd0, 0, 1, 0, "R2 enter B");
    sw_check(1, 1, 15, "R5 count at max");
    do_req(3'd0, B, 0, 1, 3'd4, 0, 1, 0, "R5 enter at max");
    sw_check(1, 1, 15, "R5 max kept");

    do_req(3'd1, C, 0, 1, 3'd1, 0, 0, 0, "R4 exit miss");
    sw_check(1, 1, 15, "R4 e1 unchanged");
    sw_check(0, 1, 0, "R4 e0 unchanged");

    // software write together with a request
    @(negedge clk);
    sw_we = 1'b1; sw_idx = 0; sw_field = 2'd0; sw_wdata = C;
    req_valid = 1'b1; req_op = 3'd2; req_hdr = 32'h0000_0003;
    begin
      exp_t e;
      e.trap = 0; e.cause = 0; e.rel = 0; e.idx = 0; e.hdr = 0; e.tag = "R10 hread";
      sb.push_back(e);
    end
    @(negedge clk);
    sw_we = 1'b0; req_valid = 1'b0;
    sw_check(0, 0, A, "R10 write dropped");

    sw_write(1, 0, A);
    do_req(3'd0, A, 0, 0, 3'd0, 0, 0, 0, "R11 lowest index");
    sw_check(0, 1, 1, "R11 e0 counted");
    sw_check(1, 1, 15, "R11 e1 untouched");

    do_req(3'd0, C, 32'hFFFF_FFFF, 1, 3'd1, 0, 0, 0, "R12 miss hdr zero");
    do_req(3'd2, 0, 32'hABCD_0007, 0, 3'd0, 0, 0, 32'hABCD_0004, "R6 read mask");
    do_req(3'd6, 0, 32'h1234_5672, 0, 3'd0, 0, 0, 32'h1234_5670, "R6 code 6");
    do_req(3'd3, 0, 32'h1000_0000, 0, 3'd0, 0, 0, 32'h1000_0001, "R7 lock grant");
    do_req(3'd3, 0, 32'h1000_0001, 1, 3'd2, 0, 0, 32'h1000_0001, "R7 contention");
    do_req(3'd4, 0, 32'h1000_0001, 0, 3'd0, 0, 0, 32'h1000_0000, "R8 unlock");
    do_req(3'd4, 0, 32'h1000_0003, 1, 3'd3, 0, 0, 32'h1000_0002, "R8 waiter");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule